// File: doc/BRIEF.md
# Programmable Hit Delay and Pulse Shaper

This block retimes binary hits on a set of parallel channels. Each channel waits for a rising edge on its input, holds it back by a number of fine time steps set for that channel, and then drives an output pulse. The pulse length comes from that channel's configuration and does not depend on how long the input stayed high. One step is one period of the sampling clock, which runs at sixteen times the bunch clock. At a 40 MHz bunch clock one step is about 1.56 ns.

A single free-running tap counter serves every channel. When a channel accepts an edge, it stores two counter values: the step at which its pulse starts and the step at which the pulse ends. Its output then follows equality matches against the shared counter. Each channel has an 8-bit setting that is written and read back through a small register port. While a channel is waiting for its pulse to start, or while its pulse is high, it ignores any new edge.

Top module: `hit_delay_shaper`

## Requirements
- R1: While reset is asserted, and directly after it is released, every `pulse_o` bit is low and every channel setting reads back as 0.
- R2: Each channel setting is 8 bits. Bits [4:0] hold the delay code d (0..31) and bits [7:5] hold the width code w (0..7). A write with `cfg_we_i` high takes effect at the next clock edge. `cfg_rdata_o` shows the setting addressed by `cfg_addr_i` with no delay, and a write to one channel leaves every other channel unchanged.
- R3: `hit_i[n]` is first seen high at clock edge E0. The first clock edge at which `pulse_o[n]` goes high is E0+1+d. With d = 0 only the one-cycle pipeline latency remains.
- R4: An output pulse is high for exactly 10 + 2·w clock cycles. The range is 10 to 24, and code 4 gives 18 steps, about 28 ns at 40 MHz. The pulse length does not depend on how long the input stays high.
- R5: A rising input edge that arrives while the channel is waiting for its delay to run out, or while its pulse is high, is ignored. No extra pulse comes out and the pulse in progress is not lengthened.
- R6: Only a low-to-high transition starts a pulse. An input held high produces one pulse.
- R7: Channels are independent. Each channel uses its own delay and width, and a channel with no input edge stays low.
- R8: A channel takes its delay and width when it accepts an edge. A write that lands later does not change the pulse in progress, and it applies to the next pulse.
- R9: Delay and width are the same whatever the phase of the shared tap counter when the edge arrives, including cases where the pulse crosses the counter wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock, one tap per period |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hit_i | input | NCH | Binary hit per channel, synchronous to clk_i |
| cfg_we_i | input | 1 | Setting write enable |
| cfg_addr_i | input | AW | Channel selected for write and read |
| cfg_wdata_i | input | 8 | Setting to write: {width[2:0], delay[4:0]} |
| cfg_rdata_o | output | 8 | Setting of the addressed channel |
| pulse_o | output | NCH | Delayed, shaped output pulse per channel |

## Verification
A wrong start target shows up as a pulse edge that lands at the wrong step. It appears within one turn of the tap counter, at most 64 cycles after the input edge. A channel stuck in its high state, or an end target that is never matched, produces a pulse longer than 24 cycles, so a run-length watch on each output exposes it within 25 cycles. A miscounted width or a late retrigger shows up as a pulse length outside the set of allowed even values, at the falling edge of that pulse. Tests that start edges at many counter phases make sure that a comparison error near the counter wrap cannot stay hidden.

// File: rtl/hds_pkg.sv
`timescale 1ns/1ps
package hds_pkg;
  localparam int unsigned DLY_W    = 5;
  localparam int unsigned WID_W    = 3;
  localparam int unsigned CFG_W    = DLY_W + WID_W;
  localparam int unsigned BASE_LEN = 10;
  localparam int unsigned MAX_DLY  = (1 << DLY_W) - 1;
  localparam int unsigned MAX_LEN  = BASE_LEN + 2 * ((1 << WID_W) - 1);
  // counter must not revisit a target before it is matched
  localparam int unsigned CNT_W    = $clog2(MAX_DLY + MAX_LEN + 2);

  typedef struct packed {
    logic [WID_W-1:0] wid;
    logic [DLY_W-1:0] dly;
  } chan_cfg_t;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_WAIT = 2'd1,
    S_HIGH = 2'd2
  } chan_state_e;
endpackage

// File: rtl/hds_tap_counter.sv
`timescale 1ns/1ps
module hds_tap_counter #(
  parameter int unsigned W = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_o <= '0;
    else         cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/hds_cfg_regs.sv
`timescale 1ns/1ps
module hds_cfg_regs
  import hds_pkg::*;
#(
  parameter int unsigned NCH = 8,
  parameter int unsigned AW  = 3
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      we_i,
  input  logic [AW-1:0]             addr_i,
  input  logic [CFG_W-1:0]          wdata_i,
  output logic [NCH-1:0][CFG_W-1:0] cfg_o,
  output logic [CFG_W-1:0]          rdata_o
);
  for (genvar g = 0; g < NCH; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 cfg_o[g] <= '0;
      else if (we_i && (32'(addr_i) == 32'(g)))    cfg_o[g] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NCH; i++)
      if (32'(addr_i) == 32'(i)) rdata_o = cfg_o[i];
  end
endmodule

// File: rtl/hds_chan.sv
`timescale 1ns/1ps
module hds_chan
  import hds_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hit_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  chan_cfg_t        cfg_i,
  output logic             pulse_o
);
  chan_state_e      state_q;
  logic             hit_q, hit_qq;
  logic [CNT_W-1:0] start_q, end_q;
  logic             rise;
  logic [CNT_W-1:0] dly_ext, len_ext;

  assign rise    = hit_q & ~hit_qq;
  assign dly_ext = CNT_W'(cfg_i.dly);
  assign len_ext = CNT_W'(BASE_LEN) + CNT_W'({cfg_i.wid, 1'b0});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_q  <= 1'b0;
      hit_qq <= 1'b0;
    end else begin
      hit_q  <= hit_i;
      hit_qq <= hit_q;
    end
  end

  // targets captured once per accepted edge; later edges ignored until idle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      start_q <= '0;
      end_q   <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: if (rise) begin
          start_q <= cnt_i + dly_ext;
          end_q   <= cnt_i + dly_ext + len_ext;
          state_q <= (cfg_i.dly == '0) ? S_HIGH : S_WAIT;
        end
        S_WAIT: if (cnt_i == start_q) state_q <= S_HIGH;
        S_HIGH: if (cnt_i == end_q)   state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign pulse_o = (state_q == S_HIGH);
endmodule

// File: rtl/hit_delay_shaper.sv
`timescale 1ns/1ps
module hit_delay_shaper
  import hds_pkg::*;
#(
  parameter  int unsigned NCH = 8,
  localparam int unsigned AW  = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NCH-1:0]   hit_i,
  input  logic             cfg_we_i,
  input  logic [AW-1:0]    cfg_addr_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  output logic [CFG_W-1:0] cfg_rdata_o,
  output logic [NCH-1:0]   pulse_o
);
  logic [CNT_W-1:0]          tap_cnt;
  logic [NCH-1:0][CFG_W-1:0] cfg;

  hds_tap_counter #(.W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cnt_o  (tap_cnt)
  );

  hds_cfg_regs #(.NCH(NCH), .AW(AW)) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .addr_i  (cfg_addr_i),
    .wdata_i (cfg_wdata_i),
    .cfg_o   (cfg),
    .rdata_o (cfg_rdata_o)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    hds_chan u_ch (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .hit_i   (hit_i[g]),
      .cnt_i   (tap_cnt),
      .cfg_i   (chan_cfg_t'(cfg[g])),
      .pulse_o (pulse_o[g])
    );
  end
endmodule

// File: rtl/hit_delay_shaper_chk.sv
`timescale 1ns/1ps
module hit_delay_shaper_chk
  import hds_pkg::*;
#(
  parameter int unsigned NCH = 8,
  parameter int unsigned AW  = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [NCH-1:0]   pulse_o,
  input logic [CNT_W-1:0] tap_cnt,
  input logic             cfg_we_i,
  input logic [AW-1:0]    cfg_addr_i,
  input logic [CFG_W-1:0] cfg_wdata_i,
  input logic [CFG_W-1:0] cfg_rdata_o
);
  logic armed_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= 1'b1;
  end

  a_r1_quiet_in_reset: assert property (@(posedge clk_i)
    !rst_ni |-> pulse_o == '0);

  a_r2_readback: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q && $past(cfg_we_i) && (cfg_addr_i == $past(cfg_addr_i))
      && (32'(cfg_addr_i) < NCH) |-> cfg_rdata_o == $past(cfg_wdata_i));

  a_r9_tap_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q |-> tap_cnt == $past(tap_cnt) + 1'b1);

  for (genvar g = 0; g < NCH; g++) begin : g_run
    logic [7:0] run_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         run_q <= '0;
      else if (!pulse_o[g]) run_q <= '0;
      else if (run_q != '1) run_q <= run_q + 1'b1;
    end

    a_r4_len_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
      run_q <= 8'(MAX_LEN));

    a_r4_len_at_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(pulse_o[g]) |-> (run_q >= 8'(BASE_LEN)) && (run_q <= 8'(MAX_LEN))
        && (run_q[0] == 1'(BASE_LEN % 2)));
  end
endmodule

bind hit_delay_shaper hit_delay_shaper_chk #(.NCH(NCH), .AW(AW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .pulse_o     (pulse_o),
  .tap_cnt     (tap_cnt),
  .cfg_we_i    (cfg_we_i),
  .cfg_addr_i  (cfg_addr_i),
  .cfg_wdata_i (cfg_wdata_i),
  .cfg_rdata_o (cfg_rdata_o)
);

// File: tb/sim_hit_delay_shaper.sv
`timescale 1ns/1ps
module sim_hit_delay_shaper;
  localparam int NCH = 8;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [NCH-1:0] hit = '0;
  logic           we = 1'b0;
  logic [2:0]     addr = '0;
  logic [7:0]     wdata = '0;
  logic [7:0]     rdata;
  logic [NCH-1:0] pulse;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  int rise_k [NCH];
  int len_k  [NCH];
  int nrise  [NCH];

  always #4 clk = ~clk;

  hit_delay_shaper #(.NCH(NCH)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .hit_i(hit), .cfg_we_i(we),
    .cfg_addr_i(addr), .cfg_wdata_i(wdata), .cfg_rdata_o(rdata), .pulse_o(pulse)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int ch, input int d, input int w);
    @(negedge clk);
    we = 1'b1; addr = 3'(ch); wdata = {3'(w), 5'(d)};
    @(negedge clk);
    we = 1'b0;
  endtask

  // drive pat[k] on masked channels at negedge k, record pulses seen there
  task automatic run(input logic [NCH-1:0] mask, input logic [63:0] pat, input int cycles);
    logic [NCH-1:0] prev;
    for (int c = 0; c < NCH; c++) begin rise_k[c] = 0; len_k[c] = 0; nrise[c] = 0; end
    prev = pulse;
    for (int k = 0; k < cycles; k++) begin
      @(negedge clk);
      for (int c = 0; c < NCH; c++)
        if (pulse[c]) begin
          len_k[c]++;
          if (!prev[c]) begin nrise[c]++; if (rise_k[c] == 0) rise_k[c] = k; end
        end
      prev = pulse;
      hit = (hit & ~mask) | (mask & {NCH{(k < 64) ? pat[k] : 1'b0}});
    end
    hit = hit & ~mask;
  endtask

  task automatic t_reset;
    chk("R1 pulse in reset", int'(pulse), 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R1 pulse after reset", int'(pulse), 0);
    for (int c = 0; c < NCH; c++) begin
      addr = 3'(c); #1;
      chk("R1 cfg reset value", int'(rdata), 0);
    end
  endtask

  task automatic t_cfg;
    wr(3, 21, 6);
    addr = 3'd3; #1;
    chk("R2 readback ch3", int'(rdata), 'hD5);
    wr(6, 9, 1);
    addr = 3'd6; #1;
    chk("R2 readback ch6", int'(rdata), 'h29);
    addr = 3'd3; #1;
    chk("R2 ch3 untouched", int'(rdata), 'hD5);
  endtask

  task automatic t_delay;
    int dl [5] = '{0, 1, 2, 17, 31};
    foreach (dl[i]) begin
      wr(2, dl[i], 0);
      run(8'h04, 64'h3, 70);
      chk("R3 delay start", rise_k[2], 2 + dl[i]);
      chk("R3 width at w0", len_k[2], 10);
      chk("R3 one pulse", nrise[2], 1);
    end
  endtask

  task automatic t_width;
    for (int w = 0; w < 8; w++) begin
      wr(4, 3, w);
      run(8'h10, 64'h1, 60);
      chk("R4 width", len_k[4], 10 + 2 * w);
      chk("R4 start", rise_k[4], 5);
    end
  endtask

  task automatic t_ignore;
    wr(1, 5, 0);
    // edges at k=0 (accepted), k=4 (while waiting), k=10 (while high)
    run(8'h02, 64'h413, 60);
    chk("R5 start", rise_k[1], 7);
    chk("R5 length", len_k[1], 10);
    chk("R5 no extra pulse", nrise[1], 1);
  endtask

  task automatic t_level;
    wr(7, 0, 0);
    run(8'h80, 64'h0FFF_FFFF_FFFF_FFFF, 70);
    chk("R6 held level one pulse", nrise[7], 1);
    chk("R6 length", len_k[7], 10);
    chk("R6 start", rise_k[7], 2);
  endtask

  task automatic t_indep;
    wr(0, 3, 1);
    wr(5, 20, 7);
    wr(6, 0, 0);
    run(8'h21, 64'h1, 70);
    chk("R7 ch0 start", rise_k[0], 5);
    chk("R7 ch0 length", len_k[0], 12);
    chk("R7 ch5 start", rise_k[5], 22);
    chk("R7 ch5 length", len_k[5], 24);
    chk("R7 ch6 idle", nrise[6], 0);
  endtask

  task automatic t_snapshot;
    wr(1, 4, 0);
    fork
      run(8'h02, 64'h1, 60);
      begin repeat (2) @(negedge clk); wr(1, 31, 7); end
    join
    chk("R8 old delay kept", rise_k[1], 6);
    chk("R8 old width kept", len_k[1], 10);
    run(8'h02, 64'h1, 70);
    chk("R8 new delay used", rise_k[1], 33);
    chk("R8 new width used", len_k[1], 24);
  endtask

  task automatic t_phase;
    wr(3, 31, 7);
    wr(2, 13, 2);
    for (int j = 0; j < 6; j++) begin
      repeat (j * 5 + 1) @(negedge clk);
      run(8'h0C, 64'h1, 70);
      chk("R9 ch3 start", rise_k[3], 33);
      chk("R9 ch3 length", len_k[3], 24);
      chk("R9 ch2 start", rise_k[2], 15);
      chk("R9 ch2 length", len_k[2], 14);
    end
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=1 exp=0");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_cfg();
    t_delay();
    t_width();
    t_ignore();
    t_level();
    t_indep();
    t_snapshot();
    t_phase();
    done = 1;
    summary();
    $finish;
  end
endmodule